// File: doc/BRIEF.md
# Two-wire bus slave byte transceiver

This block is the slave-side bit engine that sits between a two-wire serial bus (I2C style) and a small byte memory. It samples the bus clock and data lines with the system clock and finds the Start and Stop conditions. It receives address and data bytes and acknowledges each one. When the master asks for a read, it sends bytes that the memory side supplies. Both lines are open-drain, so the block never drives SDA high. Its single SDA control is an output enable, and a high enable pulls the line low.

Every received byte appears on a one-cycle strobe with its data. A flag marks the first byte after a Start, which carries the transfer direction in its least significant bit. In read mode the block requests each byte with a one-cycle pulse. It checks the master's acknowledge after every byte, and a not-acknowledge makes it release the line so the master can end the transfer. A busy input from the write-cycle timer keeps the block silent: while busy is high it acknowledges nothing. The system clock must run at least 8 times faster than SCL.

Top module: `twb_slave_xcvr`

## Requirements
- R1: A falling SDA while SCL is high (Start) begins a new transaction from any state, including in the middle of a byte (a repeated Start). The bit count restarts, and the next received byte is strobed with rx_first_o = 1. Later bytes are strobed with rx_first_o = 0.
- R2: A rising SDA while SCL is high (Stop) returns the block to idle with sda_oe_o = 0. SCL pulses that follow are ignored until the next Start: there is no acknowledge and no strobe.
- R3: After a Start, SDA is sampled on each SCL rise, most significant bit first. When SCL falls after the eighth rise, rx_valid_o is high for exactly one system clock cycle, and rx_data_o holds the byte during that cycle.
- R4: After each received byte, sda_oe_o is 1 from the eighth SCL fall to the ninth SCL fall, so SDA stays low for the whole high phase of the ninth pulse. Outside Start and Stop, sda_oe_o changes only while SCL is low, and it is 0 again after the ninth fall.
- R5: A transaction may carry any number of bytes. Each byte is acknowledged and strobed in turn.
- R6: If busy_i is high when the acknowledge slot of a byte begins, the block leaves SDA released and gives no strobe. It then ignores the bus until the next Start or Stop, even if busy_i falls before then.
- R7: If the first byte after a Start has its least significant bit at 1 (read), then after that byte's acknowledge rd_req_o is high for one cycle. The block takes rd_data_i in that cycle and puts its bits on SDA, most significant bit first, during the next 8 SCL pulses. For each 0 bit, sda_oe_o = 1. SDA is released on the ninth pulse.
- R8: In read mode, SDA low during the ninth pulse (master acknowledge) starts the next request and the next byte. SDA high (not-acknowledge) makes the block keep SDA released, with no more requests, until Stop or Start.
- R9: A synchronous reset (rst = 1) puts the block in idle with sda_oe_o = 0, rx_valid_o = 0 and rd_req_o = 0, even in the middle of an acknowledge.
- R10: If the first byte's least significant bit is 0 (write), the block keeps receiving and never raises rd_req_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| busy_i | input | 1 | Write cycle in progress; suppresses acknowledges |
| rd_data_i | input | DATA_W | Byte to transmit, sampled while rd_req_o is high |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | DATA_W | Received byte, valid while rx_valid_o is high |
| rx_first_o | output | 1 | Strobed byte is the first one after a Start |
| rd_req_o | output | 1 | One-cycle request for the next byte to transmit |

## Verification
The bench samples the bus at every system clock through the whole ninth high phase. A design that released its acknowledge early, or moved SDA while SCL was high, shows up as a high sample or as an unexpected Start or Stop. The bench sends a repeated Start in the middle of a byte and checks that the next byte is a fresh first byte carrying the read bit. A design that did not clear its bit count would misalign that byte and strobe the wrong value. It raises busy and then drops it before Stop, which catches a design that starts acknowledging again in the middle of a transaction. After a not-acknowledge it clocks a whole further byte and expects all ones with no new request, which exposes a design that keeps driving read data.

// File: rtl/twb_pkg.sv
package twb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RX   = 3'd1,
      ST_TXLD = 3'd2,
      ST_TX   = 3'd3,
      ST_HOLD = 3'd4
   } twb_state_e;

endpackage

// File: rtl/twb_bus_sampler.sv
module twb_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_prev;
   logic                   sda_prev;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) begin
                  scl_pipe[0] <= 1'b1;
                  sda_pipe[0] <= 1'b1;
               end else begin
                  scl_pipe[0] <= scl_i;
                  sda_pipe[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) begin
                  scl_pipe[g] <= 1'b1;
                  sda_pipe[g] <= 1'b1;
               end else begin
                  scl_pipe[g] <= scl_pipe[g-1];
                  sda_pipe[g] <= sda_pipe[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_pipe[SYNC_STAGES-1];
         sda_prev <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[SYNC_STAGES-1];
   assign sda_o      = sda_pipe[SYNC_STAGES-1];
   assign scl_rise_o = scl_o & ~scl_prev;
   assign scl_fall_o = ~scl_o & scl_prev;
   assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
   assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/twb_bit_counter.sv
module twb_bit_counter #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             full_o,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == LAST);
   assign zero_o = (cnt_q == '0);

   // R3: the count never goes past one full byte
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

endmodule

// File: rtl/twb_shifter.sv
module twb_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              shift_in_i,
   input  logic              bit_i,
   input  logic              shift_out_i,
   output logic [DATA_W-1:0] data_o,
   output logic              msb_o,
   output logic              lsb_o
);

   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q <= '1;
      end else if (load_i) begin
         sh_q <= load_data_i;
      end else if (shift_in_i) begin
         sh_q <= {sh_q[DATA_W-2:0], bit_i};
      end else if (shift_out_i) begin
         sh_q <= {sh_q[DATA_W-2:0], 1'b1};
      end
   end

   assign data_o = sh_q;
   assign msb_o  = sh_q[DATA_W-1];
   assign lsb_o  = sh_q[0];

endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
   import twb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sda_s_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic start_i,
   input  logic stop_i,
   input  logic busy_i,
   input  logic cnt_full_i,
   input  logic cnt_zero_i,
   input  logic sh_msb_i,
   input  logic sh_lsb_i,
   output logic cnt_clr_o,
   output logic cnt_inc_o,
   output logic sh_load_o,
   output logic sh_in_o,
   output logic sh_out_o,
   output logic sda_oe_o,
   output logic rx_valid_o,
   output logic rx_first_o,
   output logic rd_req_o
);

   twb_state_e st_q, st_d;
   logic in_ack_q, in_ack_d;
   logic first_q, first_d;
   logic rw_q, rw_d;
   logic mack_q, mack_d;
   logic valid_q, valid_d;
   logic req_q, req_d;

   always_comb begin
      st_d      = st_q;
      in_ack_d  = in_ack_q;
      first_d   = first_q;
      rw_d      = rw_q;
      mack_d    = mack_q;
      valid_d   = 1'b0;
      req_d     = 1'b0;
      cnt_clr_o = 1'b0;
      cnt_inc_o = 1'b0;
      sh_load_o = 1'b0;
      sh_in_o   = 1'b0;
      sh_out_o  = 1'b0;
      if (stop_i) begin
         st_d     = ST_IDLE;
         in_ack_d = 1'b0;
      end else if (start_i) begin
         st_d      = ST_RX;
         in_ack_d  = 1'b0;
         first_d   = 1'b1;
         cnt_clr_o = 1'b1;
      end else begin
         case (st_q)
            ST_RX: begin
               if (rise_i && !cnt_full_i) begin
                  sh_in_o   = 1'b1;
                  cnt_inc_o = 1'b1;
               end else if (fall_i && cnt_full_i) begin
                  if (!in_ack_q) begin
                     if (busy_i) begin
                        st_d = ST_HOLD;
                     end else begin
                        in_ack_d = 1'b1;
                        valid_d  = 1'b1;
                        if (first_q) begin
                           rw_d = sh_lsb_i;
                        end
                     end
                  end else begin
                     in_ack_d  = 1'b0;
                     cnt_clr_o = 1'b1;
                     first_d   = 1'b0;
                     if (first_q && rw_q) begin
                        st_d  = ST_TXLD;
                        req_d = 1'b1;
                     end
                  end
               end
            end
            ST_TXLD: begin
               sh_load_o = 1'b1;
               st_d      = ST_TX;
            end
            ST_TX: begin
               if (rise_i) begin
                  if (in_ack_q) begin
                     mack_d = ~sda_s_i;
                  end else if (!cnt_full_i) begin
                     cnt_inc_o = 1'b1;
                  end
               end else if (fall_i) begin
                  if (in_ack_q) begin
                     in_ack_d  = 1'b0;
                     cnt_clr_o = 1'b1;
                     if (mack_q) begin
                        st_d  = ST_TXLD;
                        req_d = 1'b1;
                     end else begin
                        st_d = ST_HOLD;
                     end
                  end else if (cnt_full_i) begin
                     in_ack_d = 1'b1;
                     mack_d   = 1'b0;
                  end else if (!cnt_zero_i) begin
                     sh_out_o = 1'b1;
                  end
               end
            end
            default: begin
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         in_ack_q <= 1'b0;
         first_q  <= 1'b0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         valid_q  <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         in_ack_q <= in_ack_d;
         first_q  <= first_d;
         rw_q     <= rw_d;
         mack_q   <= mack_d;
         valid_q  <= valid_d;
         req_q    <= req_d;
      end
   end

   assign sda_oe_o   = ((st_q == ST_RX) && in_ack_q) ||
                       ((st_q == ST_TX) && !in_ack_q && !sh_msb_i);
   assign rx_valid_o = valid_q;
   assign rx_first_o = first_q;
   assign rd_req_o   = req_q;

   // R3: a received byte is announced for one cycle only
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> !valid_q);

   // R6: an acknowledge is never started while the timer reports busy
   a_r6_busy_silent: assert property (@(posedge clk) disable iff (rst)
      ($rose(sda_oe_o) && st_q == ST_RX) |-> !$past(busy_i));

   // R7: each read request lasts a single cycle
   a_r7_req_pulse: assert property (@(posedge clk) disable iff (rst)
      req_q |=> !req_q);

   // R2: Stop always leaves the line released
   a_r2_stop_release: assert property (@(posedge clk) disable iff (rst)
      stop_i |=> !sda_oe_o);

endmodule

// File: rtl/twb_slave_xcvr.sv
module twb_slave_xcvr #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_first_o,
   output logic              rd_req_o
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("twb_slave_xcvr: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twb_slave_xcvr: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             scl_s, sda_s;
   logic             scl_rise, scl_fall, start_ev, stop_ev;
   logic             cnt_clr, cnt_inc, cnt_full, cnt_zero;
   logic [CNT_W-1:0] cnt_val;
   logic             sh_load, sh_in, sh_out, sh_msb, sh_lsb;
   logic [DATA_W-1:0] sh_data;

   twb_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk        (clk),
      .rst        (rst),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_ev),
      .stop_o     (stop_ev)
   );

   twb_bit_counter #(.DATA_W(DATA_W)) u_count (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .cnt_o  (cnt_val),
      .full_o (cnt_full),
      .zero_o (cnt_zero)
   );

   twb_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst         (rst),
      .load_i      (sh_load),
      .load_data_i (rd_data_i),
      .shift_in_i  (sh_in),
      .bit_i       (sda_s),
      .shift_out_i (sh_out),
      .data_o      (sh_data),
      .msb_o       (sh_msb),
      .lsb_o       (sh_lsb)
   );

   twb_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .sda_s_i    (sda_s),
      .rise_i     (scl_rise),
      .fall_i     (scl_fall),
      .start_i    (start_ev),
      .stop_i     (stop_ev),
      .busy_i     (busy_i),
      .cnt_full_i (cnt_full),
      .cnt_zero_i (cnt_zero),
      .sh_msb_i   (sh_msb),
      .sh_lsb_i   (sh_lsb),
      .cnt_clr_o  (cnt_clr),
      .cnt_inc_o  (cnt_inc),
      .sh_load_o  (sh_load),
      .sh_in_o    (sh_in),
      .sh_out_o   (sh_out),
      .sda_oe_o   (sda_oe_o),
      .rx_valid_o (rx_valid_o),
      .rx_first_o (rx_first_o),
      .rd_req_o   (rd_req_o)
   );

   assign rx_data_o = sh_data;

   // R4: apart from Start/Stop, the drive only moves while SCL is low
   a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
      (!$stable(sda_oe_o) && !$past(start_ev || stop_ev)) |-> !$past(scl_s));

   // R3: the bit count is only advanced by an SCL rise
   a_r3_count_on_rise: assert property (@(posedge clk) disable iff (rst)
      (cnt_val != $past(cnt_val) && cnt_val != '0) |-> $past(scl_rise));

endmodule

// File: tb/twb_slave_xcvr_test.sv
module twb_slave_xcvr_test;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       busy = 1'b0;
   logic [7:0] rd_data;
   logic       sda_oe, rx_valid, rx_first, rd_req;
   logic [7:0] rx_data;
   wire        sda_bus = sda_m & ~sda_oe;

   int n_chk = 0;
   int n_fail = 0;
   int strobes = 0;
   int req_cnt = 0;
   logic [7:0] last_data = 8'h00;
   logic       last_first = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [7:0] pat(int k);
      return 8'(k * 8'h35) ^ 8'hC3;
   endfunction

   assign rd_data = pat(req_cnt);

   twb_slave_xcvr uut (
      .clk        (clk),
      .rst        (rst),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .busy_i     (busy),
      .rd_data_i  (rd_data),
      .sda_oe_o   (sda_oe),
      .rx_valid_o (rx_valid),
      .rx_data_o  (rx_data),
      .rx_first_o (rx_first),
      .rd_req_o   (rd_req)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         strobes++;
         last_data  <= rx_data;
         last_first <= rx_first;
      end
      if (rd_req) req_cnt++;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic bus_start();
      tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
   endtask

   task automatic bus_rstart();
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
      tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1;
      tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic bit_out(logic b);
      tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
   endtask

   task automatic write_byte(logic [7:0] b, output logic acked, output logic released);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
      acked = 1'b1;
      for (int i = 0; i < 2*Q; i++) begin
         @(negedge clk);
         if (sda_bus) acked = 1'b0;
      end
      scl_m = 1'b0;
      tick(5);
      released = !sda_oe;
   endtask

   task automatic read_byte(logic mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
         tick(Q); d[i] = sda_bus; tick(Q); scl_m = 1'b0;
      end
      tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
   endtask

   task automatic t_reset();
      tick(5);
      check(sda_oe == 1'b0, "R9", "oe at reset", sda_oe, 0);
      check(rx_valid == 1'b0 && rd_req == 1'b0, "R9", "strobes at reset", {rx_valid, rd_req}, 0);
      rst = 1'b0;
      tick(5);
   endtask

   task automatic t_write();
      logic a, r;
      int s0;
      s0 = strobes;
      bus_start();
      write_byte(8'hA0, a, r);
      check(a, "R4", "address ack low whole high phase", a, 1);
      check(r, "R4", "release after ninth fall", r, 1);
      check(last_data == 8'hA0, "R3", "first byte data", last_data, 8'hA0);
      check(last_first == 1'b1, "R1", "first flag on first byte", last_first, 1);
      write_byte(8'h5A, a, r);
      check(a && last_data == 8'h5A, "R5", "second byte ack/data", last_data, 8'h5A);
      check(last_first == 1'b0, "R1", "first flag cleared", last_first, 0);
      write_byte(8'hFF, a, r);
      check(a && last_data == 8'hFF, "R5", "byte FF", last_data, 8'hFF);
      write_byte(8'h00, a, r);
      check(a && last_data == 8'h00, "R5", "byte 00", last_data, 8'h00);
      check(strobes == s0 + 4, "R5", "strobe count", strobes - s0, 4);
      bus_stop();
      tick(5);
      check(sda_oe == 1'b0, "R2", "released after stop", sda_oe, 0);
      check(req_cnt == 0, "R10", "no read request on write", req_cnt, 0);
   endtask

   task automatic t_no_start();
      logic a, r;
      int s0;
      s0 = strobes;
      tick(Q);
      scl_m = 1'b0;
      write_byte(8'h33, a, r);
      check(!a, "R2", "no ack without start", a, 0);
      check(strobes == s0, "R2", "no strobe without start", strobes - s0, 0);
      bus_stop();
   endtask

   task automatic t_busy();
      logic a, r;
      int s0;
      s0 = strobes;
      busy = 1'b1;
      bus_start();
      write_byte(8'hA0, a, r);
      check(!a, "R6", "no ack while busy", a, 0);
      write_byte(8'h11, a, r);
      check(!a, "R6", "still silent while busy", a, 0);
      busy = 1'b0;
      write_byte(8'h22, a, r);
      check(!a, "R6", "silent until stop after busy drops", a, 0);
      check(strobes == s0, "R6", "no strobe while busy", strobes - s0, 0);
      bus_stop();
   endtask

   task automatic t_read();
      logic a, r;
      logic [7:0] d;
      int q0;
      q0 = req_cnt;
      bus_start();
      write_byte(8'hA1, a, r);
      check(a, "R7", "read address ack", a, 1);
      read_byte(1'b1, d);
      check(d == pat(q0 + 1), "R7", "read byte 1", d, pat(q0 + 1));
      read_byte(1'b1, d);
      check(d == pat(q0 + 2), "R8", "read byte after master ack", d, pat(q0 + 2));
      read_byte(1'b0, d);
      check(d == pat(q0 + 3), "R8", "last read byte", d, pat(q0 + 3));
      read_byte(1'b0, d);
      check(d == 8'hFF, "R8", "released after nak", d, 8'hFF);
      check(req_cnt == q0 + 3, "R8", "no request after nak", req_cnt - q0, 3);
      bus_stop();
   endtask

   task automatic t_rstart();
      logic a, r;
      logic [7:0] d;
      int q0;
      q0 = req_cnt;
      bus_start();
      write_byte(8'h44, a, r);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      bus_rstart();
      write_byte(8'hA1, a, r);
      check(a && last_data == 8'hA1, "R1", "byte after repeated start", last_data, 8'hA1);
      check(last_first == 1'b1, "R1", "first flag after repeated start", last_first, 1);
      read_byte(1'b0, d);
      check(d == pat(q0 + 1), "R7", "read after repeated start", d, pat(q0 + 1));
      bus_stop();
   endtask

   task automatic t_reset_mid();
      bus_start();
      for (int i = 7; i >= 0; i--) bit_out(1'b0);
      tick(Q);
      sda_m = 1'b1;
      check(sda_oe == 1'b1, "R4", "ack drive after eighth fall", sda_oe, 1);
      rst = 1'b1;
      tick(2);
      check(sda_oe == 1'b0, "R9", "reset releases during ack", sda_oe, 0);
      rst = 1'b0;
      tick(Q);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      tick(4);
      t_reset();
      t_write();
      t_no_start();
      t_busy();
      t_read();
      t_rstart();
      t_reset_mid();
      tick(10);
      finish_up();
   end

endmodule